// File: doc/BRIEF.md
# Counted-Pattern Link Self-Test Source and Sink

This block is a self-test pair for byte-wide links. The source side sends a repeating block of counted bytes and closes each block with a marker byte. The sink side receives the byte stream that comes back from the link. It locks onto the markers, compares every byte with the count it predicts, and checks that the distance between markers is correct. It reports once per block, and only when that block held an error.

The source keeps a remaining-count register that starts at 200. While the count is nonzero, the source sends the count plus one with bit 4 cleared, then steps the count down. When the count reaches zero, the source sends the marker 0x3E and loads 200 again, so one full period is 201 bytes.

The sink holds a matching remaining count and a length counter. On each marker it combines three error flags into a report: a data mismatch, a byte arriving after the count was used up, and a wrong marker spacing. The report carries the flags, the sink's next expected byte value and a mismatch count. The source and sink share only the clock and reset, so the sink can take either the looped-back source stream or any other stream.

Top module: `ptn_selftest`

## Requirements
- R1: After reset the source count is 200, so the first byte sent is 0xC9. While the count is nonzero, each byte sent is (count + 1) AND 0xEF, so bit 4 is always zero.
- R2: When the source count is zero, the source sends 0x3E and loads 200 again. Markers are therefore 201 accepted bytes apart.
- R3: `gen_valid` is low during reset and high from the first clock edge after reset. The source count changes only on a cycle where `gen_valid` and `gen_ready` are both high. While stalled, `gen_data` holds its value.
- R4: After reset the sink ignores every byte until the first marker. That marker starts the first block and produces no report.
- R5: Any byte whose low 6 bits equal 0x3E is a marker (for example 0x3E, 0x7E, 0xFE). At a marker, error bit 2 (value 4) is set if the number of bytes since the previous marker, counting this marker, is not 201.
- R6: If a non-marker byte arrives when the sink's remaining count is already zero, error bit 1 (value 2) is set. The remaining count then stays at zero.
- R7: For each non-marker byte, if (byte XOR (remaining + 1)) AND 0xEF is nonzero, error bit 0 (value 1) is set and the mismatch count increases by one, saturating at 255. A difference only in bit 4 is ignored. The remaining count then decrements.
- R8: At a marker where any error bit is set, `rpt_valid` pulses for one cycle, one clock after the marker is accepted. The pulse carries `rpt_err` (the three bits), `rpt_expect` = remaining + 1 and `rpt_miss` = the mismatch count. These fields hold until the next report. Every marker clears the flags and the mismatch count and loads 200 into the remaining count.
- R9: A block of 200 correct bytes followed by a marker produces no report. A looped-back source stream therefore never produces a report.
- R10: During reset, `rpt_valid` is low and `rpt_err`, `rpt_expect` and `rpt_miss` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_ready | input | 1 | Link accepts the source byte |
| gen_valid | output | 1 | Source byte available |
| gen_data | output | 8 | Source byte |
| chk_valid | input | 1 | Received byte strobe |
| chk_data | input | 8 | Received byte |
| rpt_valid | output | 1 | One-cycle report pulse |
| rpt_err | output | 3 | Error flags: bit 0 data mismatch, bit 1 count used up, bit 2 wrong marker spacing |
| rpt_expect | output | 8 | Remaining count + 1 at the reporting marker |
| rpt_miss | output | 8 | Saturating mismatch count of the block |

## Verification
The marker that closes a block also finishes the spacing check, so the spacing flag is formed in the same cycle as the report and the clearing of the block state. This case is provoked with blocks one byte short and one byte long, and with a long block that also carries mismatches. The bench confirms that the reported flags combine the flags raised inside the block with the spacing flag of that same marker, and that the next block starts clean. Overflow of the remaining count and mismatch saturation are both driven by a 300-byte block of wrong data. That block must report all three flags together, with a mismatch count of 255.

// File: rtl/ptn_pkg.sv
package ptn_pkg;
  localparam int unsigned BW        = 8;
  localparam int unsigned EW        = 3;
  localparam logic [5:0]  MARK_KEY  = 6'h3E;
  localparam logic [7:0]  MARK_BYTE = 8'h3E;
  localparam logic [7:0]  CMP_MASK  = 8'hEF;
  localparam int unsigned EB_DATA   = 0;
  localparam int unsigned EB_OVER   = 1;
  localparam int unsigned EB_LEN    = 2;
endpackage

// File: rtl/ptn_gen.sv
module ptn_gen
  import ptn_pkg::*;
#(
  parameter int unsigned RELOAD = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  output logic          valid,
  output logic [BW-1:0] data
);
  localparam logic [BW-1:0] RELOAD_V = BW'(RELOAD);
  localparam logic [BW-1:0] FIRST_V  = (RELOAD_V + 8'd1) & CMP_MASK;

  logic [BW-1:0] cnt_q, cnt_d;
  logic          vld_q;
  logic          fire, at_mark;

  always_comb begin
    fire    = vld_q & ready;
    at_mark = (cnt_q == '0);
    data    = at_mark ? MARK_BYTE : ((cnt_q + 8'd1) & CMP_MASK);
    cnt_d   = cnt_q;
    if (fire) cnt_d = at_mark ? RELOAD_V : (cnt_q - 8'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD_V;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      if (fire) cnt_q <= cnt_d;
    end
  end

  assign valid = vld_q;

  p_bit4_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && data != MARK_BYTE) |-> !data[4]);
  p_marker_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && data == MARK_BYTE) |=> (data == FIRST_V));
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ready) |=> $stable(data));
endmodule

// File: rtl/ptn_chk.sv
module ptn_chk
  import ptn_pkg::*;
#(
  parameter int unsigned RELOAD = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  output logic          rpt_valid,
  output logic [EW-1:0] rpt_err,
  output logic [BW-1:0] rpt_expect,
  output logic [BW-1:0] rpt_miss
);
  localparam logic [BW-1:0] RELOAD_V = BW'(RELOAD);
  localparam logic [BW-1:0] SAT_V    = '1;

  logic          sync_q, sync_d;
  logic [BW-1:0] rem_q, rem_d;
  logic [BW-1:0] len_q, len_d;
  logic [EW-1:0] flg_q, flg_d, flg_fin;
  logic [BW-1:0] miss_q, miss_d;
  logic          rv_q, rv_d;
  logic [EW-1:0] rerr_q, rerr_d;
  logic [BW-1:0] rexp_q, rexp_d;
  logic [BW-1:0] rmiss_q, rmiss_d;
  logic          is_mark, mism;

  always_comb begin
    is_mark = (in_data[5:0] == MARK_KEY);
    mism    = |((in_data ^ (rem_q + 8'd1)) & CMP_MASK);
    sync_d  = sync_q;
    rem_d   = rem_q;
    len_d   = len_q;
    flg_d   = flg_q;
    miss_d  = miss_q;
    rv_d    = 1'b0;
    rerr_d  = rerr_q;
    rexp_d  = rexp_q;
    rmiss_d = rmiss_q;
    flg_fin = flg_q;
    flg_fin[EB_LEN] = flg_q[EB_LEN] | (len_q != RELOAD_V);
    if (in_valid) begin
      if (!sync_q) begin
        if (is_mark) begin
          sync_d = 1'b1;
          rem_d  = RELOAD_V;
          len_d  = '0;
          flg_d  = '0;
          miss_d = '0;
        end
      end else if (is_mark) begin
        if (flg_fin != '0) begin
          rv_d    = 1'b1;
          rerr_d  = flg_fin;
          rexp_d  = rem_q + 8'd1;
          rmiss_d = miss_q;
        end
        rem_d  = RELOAD_V;
        len_d  = '0;
        flg_d  = '0;
        miss_d = '0;
      end else begin
        if (len_q != SAT_V) len_d = len_q + 8'd1;
        if (rem_q == '0) flg_d[EB_OVER] = 1'b1;
        if (mism) begin
          flg_d[EB_DATA] = 1'b1;
          if (miss_q != SAT_V) miss_d = miss_q + 8'd1;
        end
        if (rem_q != '0) rem_d = rem_q - 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      rem_q   <= RELOAD_V;
      len_q   <= '0;
      flg_q   <= '0;
      miss_q  <= '0;
      rv_q    <= 1'b0;
      rerr_q  <= '0;
      rexp_q  <= '0;
      rmiss_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (in_valid) begin
        sync_q  <= sync_d;
        rem_q   <= rem_d;
        len_q   <= len_d;
        flg_q   <= flg_d;
        miss_q  <= miss_d;
        rerr_q  <= rerr_d;
        rexp_q  <= rexp_d;
        rmiss_q <= rmiss_d;
      end
    end
  end

  assign rpt_valid  = rv_q;
  assign rpt_err    = rerr_q;
  assign rpt_expect = rexp_q;
  assign rpt_miss   = rmiss_q;

  p_quiet_unsynced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |=> !rv_q);
  p_report_on_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> $past(in_valid && is_mark && sync_q));
  p_report_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> (rerr_q != '0));
  p_marker_reloads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sync_q && is_mark) |=> (rem_q == RELOAD_V && miss_q == '0));
  p_remaining_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sync_q && !is_mark && rem_q == '0) |=> (rem_q == '0));
endmodule

// File: rtl/ptn_selftest.sv
module ptn_selftest
  import ptn_pkg::*;
#(
  parameter int unsigned RELOAD = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_ready,
  output logic          gen_valid,
  output logic [BW-1:0] gen_data,
  input  logic          chk_valid,
  input  logic [BW-1:0] chk_data,
  output logic          rpt_valid,
  output logic [EW-1:0] rpt_err,
  output logic [BW-1:0] rpt_expect,
  output logic [BW-1:0] rpt_miss
);
  ptn_gen #(.RELOAD(RELOAD)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (gen_ready),
    .valid (gen_valid),
    .data  (gen_data)
  );

  ptn_chk #(.RELOAD(RELOAD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (chk_valid),
    .in_data    (chk_data),
    .rpt_valid  (rpt_valid),
    .rpt_err    (rpt_err),
    .rpt_expect (rpt_expect),
    .rpt_miss   (rpt_miss)
  );
endmodule

// File: tb/tb_ptn_selftest.sv
module tb_ptn_selftest;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       gen_ready;
  logic       b_valid;
  logic [7:0] b_data;
  logic       loop;
  logic       gen_valid;
  logic [7:0] gen_data;
  logic       chk_valid;
  logic [7:0] chk_data;
  logic       rpt_valid;
  logic [2:0] rpt_err;
  logic [7:0] rpt_expect;
  logic [7:0] rpt_miss;

  int checks = 0;
  int errors = 0;

  bit       m_sync;
  int       m_rem, m_len, m_miss;
  bit [2:0] m_flg;
  bit       m_rv;
  bit [2:0] m_err;
  bit [7:0] m_exp, m_mis;
  int       g_cnt;

  assign chk_valid = loop ? (gen_valid & gen_ready) : b_valid;
  assign chk_data  = loop ? gen_data : b_data;

  ptn_selftest dut (
    .clk(clk), .rst_n(rst_n), .gen_ready(gen_ready), .gen_valid(gen_valid),
    .gen_data(gen_data), .chk_valid(chk_valid), .chk_data(chk_data),
    .rpt_valid(rpt_valid), .rpt_err(rpt_err), .rpt_expect(rpt_expect),
    .rpt_miss(rpt_miss)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] src_byte(input int cnt);
    return (cnt == 0) ? 8'h3E : 8'((cnt + 1) & 8'hEF);
  endfunction

  task automatic model_reset();
    m_sync = 0; m_rem = 200; m_len = 0; m_miss = 0; m_flg = 0;
    m_rv = 0; m_err = 0; m_exp = 0; m_mis = 0;
  endtask

  task automatic model_byte(input bit [7:0] d);
    bit mark;
    bit [2:0] f;
    mark = (d[5:0] == 6'h3E);
    m_rv = 0;
    if (!m_sync) begin
      if (mark) begin
        m_sync = 1; m_rem = 200; m_len = 0; m_flg = 0; m_miss = 0;
      end
    end else if (mark) begin
      f = m_flg;
      if (m_len != 200) f[2] = 1;
      if (f != 0) begin
        m_rv = 1; m_err = f; m_exp = 8'(m_rem + 1); m_mis = 8'(m_miss);
      end
      m_rem = 200; m_len = 0; m_flg = 0; m_miss = 0;
    end else begin
      if (m_len < 255) m_len++;
      if (m_rem == 0) m_flg[1] = 1;
      if (((d ^ 8'(m_rem + 1)) & 8'hEF) != 0) begin
        m_flg[0] = 1;
        if (m_miss < 255) m_miss++;
      end
      if (m_rem != 0) m_rem--;
    end
  endtask

  task automatic feed(input bit [7:0] d, input string req);
    b_valid = 1'b1;
    b_data  = d;
    model_byte(d);
    @(negedge clk);
    check(rpt_valid == m_rv, req, "rpt_valid", int'(rpt_valid), int'(m_rv));
    check({rpt_err, rpt_expect, rpt_miss} == {m_err, m_exp, m_mis}, req,
          "report fields", int'({rpt_err, rpt_expect, rpt_miss}),
          int'({m_err, m_exp, m_mis}));
    b_valid = 1'b0;
  endtask

  task automatic data_block(input int n, input int pct, input bit flip4,
                            input bit [7:0] mark, input string req);
    bit [7:0] d;
    for (int i = 0; i < n; i++) begin
      d = 8'((m_rem + 1) & 8'hEF);
      if (flip4) d ^= 8'h10;
      if ($urandom_range(99) < pct) begin
        int b;
        b = $urandom_range(6);
        if (b >= 4) b++;
        d ^= 8'(1 << b);
      end
      if (d[5:0] == 6'h3E) d[0] = ~d[0];
      feed(d, req);
    end
    feed(mark, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gen_ready = 1'b0; b_valid = 1'b0; b_data = 8'h00; loop = 1'b0;
    repeat (3) @(negedge clk);
    check(!gen_valid, "R10", "gen_valid in reset", int'(gen_valid), 0);
    check(gen_data == 8'hC9, "R1", "gen_data in reset", int'(gen_data), 'hC9);
    check(!rpt_valid && rpt_err == 0 && rpt_expect == 0 && rpt_miss == 0, "R10",
          "report in reset", int'({rpt_valid, rpt_err, rpt_expect, rpt_miss}), 0);
    rst_n = 1'b1;
    model_reset();
    g_cnt = 200;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [7:0] d;
    void'($urandom(32'h5EED1234));
    do_reset();
    loop = 1'b1;
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      if (i == 0) check(gen_valid, "R3", "gen_valid after reset", int'(gen_valid), 1);
      if (gen_valid)
        check(gen_data == src_byte(g_cnt), (g_cnt == 0) ? "R2" : "R1", "gen_data",
              int'(gen_data), int'(src_byte(g_cnt)));
      check(!rpt_valid, "R9", "loopback report", int'(rpt_valid), 0);
      gen_ready = ($urandom_range(9) < 7);
      if (gen_valid && gen_ready) g_cnt = (g_cnt == 0) ? 200 : g_cnt - 1;
    end
    gen_ready = 1'b0;

    do_reset();
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      d = 8'($urandom);
      if (d[5:0] == 6'h3E) d ^= 8'h01;
      feed(d, "R4");
    end
    feed(8'h7E, "R4");
    data_block(200, 0, 1'b0, 8'h3E, "R9");
    data_block(200, 0, 1'b1, 8'hFE, "R5");
    data_block(200, 20, 1'b0, 8'hBE, "R7");
    data_block(199, 0, 1'b0, 8'h3E, "R5");
    data_block(200, 0, 1'b0, 8'h3E, "R9");
    for (int i = 0; i < 200; i++) feed(8'((m_rem + 1) & 8'hEF), "R6");
    feed(8'h01, "R6");
    feed(8'h3E, "R6");
    data_block(300, 100, 1'b0, 8'h3E, "R7");
    check(m_err == 3'b111 && m_mis == 8'hFF, "R7", "saturation model",
          int'({m_err, m_mis}), 'h7FF);
    data_block(200, 0, 1'b0, 8'h3E, "R8");
    for (int k = 0; k < 30; k++)
      data_block(196 + $urandom_range(8), ($urandom_range(1) == 1) ? 3 : 0,
                 1'($urandom_range(1)), 8'h3E, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule